// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit carries out the second byte of an 8-bit processor's bit/rotate prefix group. The opcode byte is split into three fields: a group, a bit index (or operation number) and an operand selector. In the same pass the unit performs a rotate or shift, a single-bit test, a single-bit clear or a single-bit set. The operand is one of seven working registers or a memory byte. The surrounding core supplies the register values, the memory byte it has already read, the current flags and two address high bytes. The unit returns, one clock later, the result, the new flags, the write-back strobes, the T-state cost and the updated refresh counter.

In indexed mode the operand is always the memory byte at an address that the core has already computed. The result goes back to memory. For every group except bit test, it can also be copied into a register. Address generation, fetch sequencing and the bus itself stay in the core.

Top module: `bitop_unit`

## Requirements
- R1: The opcode fields are group = bits 7:6, index = bits 5:3 and selector = bits 2:0. Outside indexed mode, selector values 0,1,2,3,4,5,7 choose the registers B,C,D,E,H,L,A, held in byte slots 0..5 and 7 of `regs_in` (slot k at bits 8k+7:8k). Selector 6 chooses `mem_rdata`. For bit test, `result` returns the operand unchanged.
- R2: Group 0 shifts the operand. Index 0..7 selects in turn: rotate left circular, rotate right circular, rotate left through carry, rotate right through carry, arithmetic shift left, arithmetic shift right, shift left inserting 1, and logical shift right. Carry receives the bit shifted out. Flag layout is S=7, Z=6, Y=5, H=4, X=3, P/V=2, N=1, C=0. S, Z and P/V (even parity) follow the result, H and N are cleared, and Y/X copy result bits 5 and 3.
- R3: Bit test (group 1) sets Z and P/V when the tested bit is 0. It sets H, clears N and keeps C. S is set only when the index is 7 and the bit is 1.
- R4: For bit test, flag bits 5 and 3 come from different sources. With a register operand they come from the operand. With the pointer-addressed memory operand they come from `ptr_hi`. In indexed mode they come from `ea_hi`.
- R5: Group 2 clears bit `index` of the operand, and group 3 sets it. Both leave all flags equal to `flags_in`.
- R6: Outside indexed mode, groups 0, 2 and 3 raise `reg_we` with `reg_sel` equal to the selector when it is not 6, and raise `mem_we` when it is 6. Bit test raises neither.
- R7: Outside indexed mode the cost is 8 T-states for a register operand. The memory operand costs 12 for bit test and 15 for the other groups.
- R8: In indexed mode the operand is `mem_rdata`. Bit test costs 20 T-states and writes nothing. The other groups cost 23, raise `mem_we`, and also raise `reg_we` with `reg_sel` equal to the selector when it is not 6.
- R9: An operation outside indexed mode returns `refresh_out` with bits 6:0 equal to `refresh_in` bits 6:0 plus one (modulo 128) and bit 7 kept. An indexed operation returns `refresh_in` unchanged.
- R10: All outputs are registered. `done` and the strobes are high exactly in the cycle after `op_valid`, and low otherwise. Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute the opcode this cycle |
| idx_mode | input | 1 | Indexed form: operand is the byte at the precomputed address |
| opcode | input | 8 | Second opcode byte |
| regs_in | input | 64 | Register byte slots, slot = selector value, slot 6 unused |
| mem_rdata | input | 8 | Memory byte already read by the core |
| flags_in | input | 8 | Current flags |
| ptr_hi | input | 8 | High byte of the internal memory pointer |
| ea_hi | input | 8 | High byte of the indexed effective address |
| refresh_in | input | 8 | Current refresh counter |
| done | output | 1 | Outputs below belong to the previous cycle's opcode |
| result | output | 8 | Operation result |
| flags_out | output | 8 | New flags |
| reg_we | output | 1 | Write `result` to register `reg_sel` |
| reg_sel | output | 3 | Destination register selector |
| mem_we | output | 1 | Write `result` to the operand's memory address |
| tstates | output | 5 | T-state cost of the operation |
| refresh_out | output | 8 | Updated refresh counter |

## Verification
In indexed mode the memory write-back and the register copy happen in the same cycle, and the bench checks both strobes together. It checks that they carry the same result byte and that `reg_sel` follows the selector, and it confirms that selector 6 suppresses only the register copy. The second overlap is bit test on memory, where the flag computation meets the choice of source for the undocumented bits. There, directed and random cases drive `ptr_hi`, `ea_hi` and the operand with different bit-5/bit-3 patterns, so that taking the wrong source changes `flags_out`.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_Y = 5;
  localparam int FL_H = 4;
  localparam int FL_X = 3;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SETB  = 2'd3
  } grp_e;

  localparam logic [2:0] SEL_MEM = 3'd6;

  typedef struct packed {
    grp_e       grp;
    logic [2:0] idx;
    logic [2:0] sel;
  } fields_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
#(
  parameter int W     = 8,
  parameter int SLOTS = 8
) (
  input  logic [7:0]         opcode,
  input  logic               idx_mode,
  input  logic [SLOTS*W-1:0] regs_in,
  input  logic [W-1:0]       mem_rdata,
  output fields_t            f,
  output logic               is_mem,
  output logic [W-1:0]       operand
);

  logic [W-1:0] slot [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slot[k] = regs_in[k*W +: W];
  end

  assign f.grp = grp_e'(opcode[7:6]);
  assign f.idx = opcode[5:3];
  assign f.sel = opcode[2:0];

  assign is_mem  = idx_mode || (opcode[2:0] == SEL_MEM);
  assign operand = is_mem ? mem_rdata : slot[opcode[2:0]];

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int W = 8
) (
  input  fields_t      f,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] flags_in,
  input  logic [W-1:0] ux_src,
  output logic [W-1:0] result,
  output logic [W-1:0] flags_new
);

  logic [W-1:0] sh;
  logic         cout;
  logic         cin;
  logic         tbit;
  logic [W-1:0] mask;

  assign cin  = flags_in[FL_C];
  assign mask = W'(1) << f.idx;
  assign tbit = |(operand & mask);

  always_comb begin
    sh   = operand;
    cout = 1'b0;
    unique case (f.idx)
      3'd0: begin sh = {operand[W-2:0], operand[W-1]}; cout = operand[W-1]; end
      3'd1: begin sh = {operand[0], operand[W-1:1]};   cout = operand[0];   end
      3'd2: begin sh = {operand[W-2:0], cin};          cout = operand[W-1]; end
      3'd3: begin sh = {cin, operand[W-1:1]};          cout = operand[0];   end
      3'd4: begin sh = {operand[W-2:0], 1'b0};         cout = operand[W-1]; end
      3'd5: begin sh = {operand[W-1], operand[W-1:1]}; cout = operand[0];   end
      3'd6: begin sh = {operand[W-2:0], 1'b1};         cout = operand[W-1]; end
      default: begin sh = {1'b0, operand[W-1:1]};      cout = operand[0];   end
    endcase
  end

  always_comb begin
    result    = operand;
    flags_new = flags_in;
    unique case (f.grp)
      GRP_SHIFT: begin
        result          = sh;
        flags_new       = '0;
        flags_new[FL_S] = sh[W-1];
        flags_new[FL_Z] = (sh == '0);
        flags_new[FL_Y] = sh[FL_Y];
        flags_new[FL_X] = sh[FL_X];
        flags_new[FL_P] = ~^sh;
        flags_new[FL_C] = cout;
      end
      GRP_TEST: begin
        result          = operand;
        flags_new       = '0;
        flags_new[FL_S] = (f.idx == 3'd7) && tbit;
        flags_new[FL_Z] = ~tbit;
        flags_new[FL_Y] = ux_src[FL_Y];
        flags_new[FL_H] = 1'b1;
        flags_new[FL_X] = ux_src[FL_X];
        flags_new[FL_P] = ~tbit;
        flags_new[FL_C] = cin;
      end
      GRP_CLR:  result = operand & ~mask;
      default:  result = operand | mask;
    endcase
  end

endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
#(
  parameter int W         = 8,
  parameter int T_BASE    = 8,
  parameter int T_MEM_RMW = 7,
  parameter int T_MEM_BIT = 4,
  parameter int T_IDX_BIT = 20,
  parameter int T_IDX_RMW = 23,
  localparam int TS_W     = $clog2(T_IDX_RMW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic            idx_mode,
  input  fields_t         f,
  input  logic [W-1:0]    refresh_in,
  output logic            done,
  output logic            reg_we,
  output logic [2:0]      reg_sel,
  output logic            mem_we,
  output logic [TS_W-1:0] tstates,
  output logic [W-1:0]    refresh_out
);

  localparam logic [TS_W-1:0] TS_BASE = TS_W'(T_BASE);
  localparam logic [TS_W-1:0] TS_MRMW = TS_W'(T_BASE + T_MEM_RMW);
  localparam logic [TS_W-1:0] TS_MBIT = TS_W'(T_BASE + T_MEM_BIT);
  localparam logic [TS_W-1:0] TS_XBIT = TS_W'(T_IDX_BIT);
  localparam logic [TS_W-1:0] TS_XRMW = TS_W'(T_IDX_RMW);

  logic            writes;
  logic            to_reg;
  logic            to_mem;
  logic [TS_W-1:0] cost;
  logic [W-1:0]    rf_next;

  assign writes = (f.grp != GRP_TEST);
  assign to_mem = writes && (idx_mode || f.sel == SEL_MEM);
  assign to_reg = writes && (f.sel != SEL_MEM);

  always_comb begin
    if (idx_mode)                cost = writes ? TS_XRMW : TS_XBIT;
    else if (f.sel != SEL_MEM)   cost = TS_BASE;
    else                         cost = writes ? TS_MRMW : TS_MBIT;
  end

  assign rf_next = idx_mode ? refresh_in
                            : {refresh_in[W-1], refresh_in[W-2:0] + (W-1)'(1)};

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      reg_we      <= 1'b0;
      mem_we      <= 1'b0;
      reg_sel     <= '0;
      tstates     <= '0;
      refresh_out <= '0;
    end else begin
      done   <= op_valid;
      reg_we <= op_valid && to_reg;
      mem_we <= op_valid && to_mem;
      if (op_valid) begin
        reg_sel     <= f.sel;
        tstates     <= cost;
        refresh_out <= rf_next;
      end
    end
  end

  // R7
  reg_cost_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && !idx_mode && f.sel != SEL_MEM |=> tstates == TS_BASE);

  // R8
  idx_cost_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && idx_mode |=> (tstates == TS_XBIT) || (tstates == TS_XRMW));

  // R8
  idx_store_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && idx_mode && f.grp != GRP_TEST |=> mem_we);

  // R6
  test_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && f.grp == GRP_TEST |=> !mem_we && !reg_we);

  // R9
  refresh_top_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> refresh_out[W-1] == $past(refresh_in[W-1]));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !done && !mem_we && !reg_we);

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int W         = 8,
  parameter int T_BASE    = 8,
  parameter int T_MEM_RMW = 7,
  parameter int T_MEM_BIT = 4,
  parameter int T_IDX_BIT = 20,
  parameter int T_IDX_RMW = 23,
  localparam int SLOTS    = 8,
  localparam int TS_W     = $clog2(T_IDX_RMW + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic               idx_mode,
  input  logic [7:0]         opcode,
  input  logic [SLOTS*W-1:0] regs_in,
  input  logic [W-1:0]       mem_rdata,
  input  logic [W-1:0]       flags_in,
  input  logic [W-1:0]       ptr_hi,
  input  logic [W-1:0]       ea_hi,
  input  logic [W-1:0]       refresh_in,
  output logic               done,
  output logic [W-1:0]       result,
  output logic [W-1:0]       flags_out,
  output logic               reg_we,
  output logic [2:0]         reg_sel,
  output logic               mem_we,
  output logic [TS_W-1:0]    tstates,
  output logic [W-1:0]       refresh_out
);

  fields_t      f;
  logic         is_mem;
  logic [W-1:0] operand;
  logic [W-1:0] ux_src;
  logic [W-1:0] alu_res;
  logic [W-1:0] alu_flags;

  bitop_decode #(.W(W), .SLOTS(SLOTS)) u_dec (
    .opcode    (opcode),
    .idx_mode  (idx_mode),
    .regs_in   (regs_in),
    .mem_rdata (mem_rdata),
    .f         (f),
    .is_mem    (is_mem),
    .operand   (operand)
  );

  // undocumented-bit source for bit test: effective address, pointer, or operand
  assign ux_src = idx_mode ? ea_hi : (is_mem ? ptr_hi : operand);

  bitop_alu #(.W(W)) u_alu (
    .f         (f),
    .operand   (operand),
    .flags_in  (flags_in),
    .ux_src    (ux_src),
    .result    (alu_res),
    .flags_new (alu_flags)
  );

  bitop_ctrl #(
    .W(W), .T_BASE(T_BASE), .T_MEM_RMW(T_MEM_RMW), .T_MEM_BIT(T_MEM_BIT),
    .T_IDX_BIT(T_IDX_BIT), .T_IDX_RMW(T_IDX_RMW)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .idx_mode    (idx_mode),
    .f           (f),
    .refresh_in  (refresh_in),
    .done        (done),
    .reg_we      (reg_we),
    .reg_sel     (reg_sel),
    .mem_we      (mem_we),
    .tstates     (tstates),
    .refresh_out (refresh_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flags_out <= '0;
    end else if (op_valid) begin
      result    <= alu_res;
      flags_out <= alu_flags;
    end
  end

  // R5
  keep_flags_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && opcode[7] |=> flags_out == $past(flags_in));

  // R3
  test_flags_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && opcode[7:6] == 2'd1 |=>
      flags_out[FL_H] && !flags_out[FL_N] && flags_out[FL_C] == $past(flags_in[FL_C]));

  // R3
  test_zp_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && opcode[7:6] == 2'd1 |=> flags_out[FL_Z] == flags_out[FL_P]);

  // R2
  shift_hn_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && opcode[7:6] == 2'd0 |=>
      !flags_out[FL_H] && !flags_out[FL_N] && flags_out[FL_Z] == (result == '0));

endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic        idx_mode;
  logic [7:0]  opcode;
  logic [63:0] regs_in;
  logic [7:0]  mem_rdata, flags_in, ptr_hi, ea_hi, refresh_in;
  logic        done, reg_we, mem_we;
  logic [7:0]  result, flags_out, refresh_out;
  logic [2:0]  reg_sel;
  logic [4:0]  tstates;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bitop_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .idx_mode(idx_mode), .opcode(opcode),
    .regs_in(regs_in), .mem_rdata(mem_rdata), .flags_in(flags_in), .ptr_hi(ptr_hi),
    .ea_hi(ea_hi), .refresh_in(refresh_in), .done(done), .result(result),
    .flags_out(flags_out), .reg_we(reg_we), .reg_sel(reg_sel), .mem_we(mem_we),
    .tstates(tstates), .refresh_out(refresh_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (op=%02h idx=%0b)", tag, act, exp, opcode, idx_mode);
    end
  endtask

  // expected values from the requirements
  logic [7:0] e_res, e_fl, e_rf;
  logic       e_rwe, e_mwe;
  logic [2:0] e_sel;
  logic [4:0] e_ts;

  task automatic model();
    logic [1:0] x = opcode[7:6];
    logic [2:0] y = opcode[5:3];
    logic [2:0] z = opcode[2:0];
    logic [7:0] v, r, src;
    logic c, b;
    v = (idx_mode || z == 3'd6) ? mem_rdata : regs_in[z*8 +: 8];
    r = v; c = 1'b0;
    e_fl = flags_in;
    if (x == 2'd0) begin
      case (y)
        3'd0: begin c = v[7]; r = {v[6:0], v[7]}; end
        3'd1: begin c = v[0]; r = {v[0], v[7:1]}; end
        3'd2: begin c = v[7]; r = {v[6:0], flags_in[0]}; end
        3'd3: begin c = v[0]; r = {flags_in[0], v[7:1]}; end
        3'd4: begin c = v[7]; r = {v[6:0], 1'b0}; end
        3'd5: begin c = v[0]; r = {v[7], v[7:1]}; end
        3'd6: begin c = v[7]; r = {v[6:0], 1'b1}; end
        default: begin c = v[0]; r = {1'b0, v[7:1]}; end
      endcase
      e_fl = {r[7], r == 8'h00, r[5], 1'b0, r[3], ~^r, 1'b0, c};
    end else if (x == 2'd1) begin
      b = v[y];
      src = idx_mode ? ea_hi : (z == 3'd6 ? ptr_hi : v);
      e_fl = {(y == 3'd7) && b, ~b, src[5], 1'b1, src[3], ~b, 1'b0, flags_in[0]};
    end else if (x == 2'd2) r = v & ~(8'h01 << y);
    else r = v | (8'h01 << y);
    e_res = r;
    e_sel = z;
    e_rwe = (x != 2'd1) && (z != 3'd6);
    e_mwe = (x != 2'd1) && (idx_mode || z == 3'd6);
    if (idx_mode) e_ts = (x == 2'd1) ? 5'd20 : 5'd23;
    else if (z != 3'd6) e_ts = 5'd8;
    else e_ts = (x == 2'd1) ? 5'd12 : 5'd15;
    e_rf = idx_mode ? refresh_in : {refresh_in[7], refresh_in[6:0] + 7'd1};
  endtask

  task automatic run_op(input logic idx, input logic [7:0] op, input logic [7:0] mem,
                        input logic [7:0] fl, input logic [7:0] ph, input logic [7:0] eh,
                        input logic [7:0] rf);
    string rtag, ftag, stag, ttag;
    op_valid = 1'b1; idx_mode = idx; opcode = op; mem_rdata = mem;
    flags_in = fl; ptr_hi = ph; ea_hi = eh; refresh_in = rf;
    model();
    case (op[7:6])
      2'd0: begin rtag = "R1 R2 result"; ftag = "R2 flags"; end
      2'd1: begin rtag = "R1 test result"; ftag = "R3 flags"; end
      default: begin rtag = "R5 result"; ftag = "R5 flags"; end
    endcase
    stag = idx ? "R8 strobes" : "R6 strobes";
    ttag = idx ? "R8 tstates" : "R7 tstates";
    @(negedge clk);
    chk("R10 done", done, 1);
    chk(rtag, result, e_res);
    if (op[7:6] == 2'd1) begin
      chk(ftag, flags_out & 8'hD7, e_fl & 8'hD7);
      chk("R4 undoc flags", flags_out & 8'h28, e_fl & 8'h28);
    end else chk(ftag, flags_out, e_fl);
    chk(stag, {reg_we, mem_we}, {e_rwe, e_mwe});
    if (e_rwe) chk(idx ? "R8 reg_sel" : "R6 reg_sel", reg_sel, e_sel);
    chk(ttag, tstates, e_ts);
    chk("R9 refresh", refresh_out, e_rf);
  endtask

  task automatic idle_cycle();
    op_valid = 1'b0; opcode = $urandom; idx_mode = $urandom;
    @(negedge clk);
    chk("R10 idle strobes", {done, reg_we, mem_we}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C8B));
    rst = 1'b1; op_valid = 1'b0; idx_mode = 1'b0; opcode = 8'h00;
    regs_in = 64'h1177_2233_4455_6688; mem_rdata = 8'h00; flags_in = 8'h00;
    ptr_hi = 8'h00; ea_hi = 8'h00; refresh_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 reset done", done, 0);
    chk("R10 reset result", result, 0);
    chk("R10 reset flags", flags_out, 0);
    chk("R10 reset strobes", {reg_we, mem_we}, 0);
    chk("R10 reset tstates", tstates, 0);
    chk("R10 reset refresh", refresh_out, 0);
    rst = 1'b0;
    idle_cycle();

    // directed corners
    regs_in = 64'hA5_00_3C_81_7F_01_FF_80;
    run_op(1'b0, 8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 8'h7F);   // SLL B=0x80, refresh 7F->00
    run_op(1'b0, 8'h10, 8'h00, 8'h01, 8'h00, 8'h00, 8'hFF);   // RL B with carry, refresh FF->80
    run_op(1'b0, 8'h18, 8'h00, 8'h01, 8'h00, 8'h00, 8'h10);   // RR B with carry
    run_op(1'b0, 8'h2F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);   // SRA A=0xA5
    run_op(1'b0, 8'h7E, 8'h80, 8'h00, 8'h28, 8'h00, 8'h00);   // BIT 7 mem, ptr bits
    run_op(1'b0, 8'h46, 8'h01, 8'hFF, 8'h00, 8'h28, 8'h00);   // BIT 0 mem, ptr clear
    run_op(1'b0, 8'h5D, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00);   // BIT 3 L, from operand
    run_op(1'b1, 8'h4E, 8'hFE, 8'h01, 8'h00, 8'h28, 8'h00);   // indexed BIT 1, ea bits
    run_op(1'b1, 8'hC0, 8'h10, 8'h5A, 8'hFF, 8'h00, 8'h33);   // indexed SET 0 copy to B
    run_op(1'b1, 8'hC6, 8'h10, 8'h5A, 8'hFF, 8'h00, 8'h33);   // indexed SET 0, no copy
    run_op(1'b1, 8'hBF, 8'hFF, 8'hA5, 8'h00, 8'h00, 8'h44);   // indexed RES 7 copy to A
    run_op(1'b0, 8'hB6, 8'hFF, 8'hC3, 8'h00, 8'h00, 8'h00);   // RES 6 mem
    idle_cycle();

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      regs_in = {$urandom, $urandom};
      run_op(($urandom % 4) == 0, 8'($urandom), 8'($urandom), 8'($urandom),
             8'($urandom), 8'($urandom), 8'($urandom));
      if ((i % 37) == 0) idle_cycle();
    end

    op_valid = 1'b0;
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule